// File: doc/BRIEF.md
# Element Zero-Run and Set-Bit Counter

This block takes one element of a vector and returns a single count for it. The count is one of three kinds: the leading zeros, the trailing zeros, or the number of set bits. The element width is chosen anew for each operation and may be 8, 16, 32 or 64 bits. The element sits in the low bits of a 64-bit operand. Every count is taken relative to the chosen element width. An element with no set bits therefore reports its own width as both its leading-zero and its trailing-zero count, not a fixed 64.

The block has one registered stage. A request presented with `in_valid` high yields `out_valid` on the next clock, with the count zero-extended into a 64-bit result. The surrounding vector datapath issues one element per cycle. That datapath handles element looping, masking and writeback.

Top module: `ecnt_unit`

## Requirements
- R1: With `in_op` = 2'b00, the result is the number of zero bits scanned from bit SEW-1 downward before the first set bit.
- R2: With `in_op` = 2'b01, the result is the number of zero bits scanned from bit 0 upward before the first set bit.
- R3: With `in_op` = 2'b10, the result is the number of set bits among bits 0 to SEW-1 of the operand.
- R4: When bits 0 to SEW-1 are all zero, both the leading-zero count (2'b00) and the trailing-zero count (2'b01) return SEW.
- R5: `in_ew` selects SEW for each request: 2'b00 = 8, 2'b01 = 16, 2'b10 = 32, 2'b11 = 64. Back-to-back requests may each use a different width.
- R6: Operand bits at positions SEW and above have no effect on any result.
- R7: The count occupies `out_result[6:0]`, and `out_result[63:7]` is always zero.
- R8: `out_valid` is high in the cycle after a cycle with `in_valid` high, and low otherwise. Reset (synchronous, active-low) clears `out_valid` and sets `out_result` to 0.
- R9: With `in_op` = 2'b11, the result is 0.
- R10: While `in_valid` is low, `out_result` holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Request strobe |
| in_op | input | 2 | Count kind: 00 leading zeros, 01 trailing zeros, 10 set bits, 11 reserved |
| in_ew | input | 2 | Element width code: 00=8, 01=16, 10=32, 11=64 |
| in_operand | input | 64 | Operand holding the element in its low SEW bits |
| out_valid | output | 1 | Result strobe, one cycle after the request |
| out_result | output | 64 | Zero-extended count |

## Verification
Every result is due exactly one clock after the edge that captures its request. The bench drives requests on falling edges and samples just after the following rising edge. At that point it pops the matching expected entry from its scoreboard queue. A queue that holds an entry while `out_valid` is low, or that is empty while `out_valid` is high, counts as a timing failure. During idle cycles the bench checks that the last result stays on the output. Operands with set bits above the element width and all-zero elements are driven at every width, so that width masking and the full-width return value are both checked at the ports.

// File: rtl/ecnt_pkg.sv
package ecnt_pkg;

   typedef enum logic [1:0] {
      OP_LEAD  = 2'b00,
      OP_TRAIL = 2'b01,
      OP_ONES  = 2'b10,
      OP_RSVD  = 2'b11
   } ecnt_op_e;

   typedef enum logic [1:0] {
      EW_8  = 2'b00,
      EW_16 = 2'b01,
      EW_32 = 2'b10,
      EW_64 = 2'b11
   } ecnt_ew_e;

   localparam int NUM_EW = 4;

endpackage

// File: rtl/ecnt_lane_select.sv
module ecnt_lane_select #(
   parameter int DATA_W = 64,
   parameter int CNT_W  = $clog2(DATA_W) + 1
) (
   input  logic [DATA_W-1:0] operand_i,
   input  logic [1:0]        ew_i,
   output logic [DATA_W-1:0] masked_o,
   output logic [DATA_W-1:0] aligned_o,
   output logic [CNT_W-1:0]  width_o,
   output logic              zero_o
);
   import ecnt_pkg::*;

   localparam int MIN_W = DATA_W / 8;

   logic [DATA_W-1:0] mask_tab [NUM_EW];
   logic [CNT_W-1:0]  shamt;

   for (genvar g = 0; g < NUM_EW; g++) begin : g_mask
      localparam int LW = MIN_W << g;
      if (LW == DATA_W) begin : g_full
         assign mask_tab[g] = '1;
      end else begin : g_part
         assign mask_tab[g] = {{(DATA_W-LW){1'b0}}, {LW{1'b1}}};
      end
   end

   assign width_o   = CNT_W'(MIN_W) << ew_i;
   assign masked_o  = operand_i & mask_tab[ew_i];
   assign shamt     = CNT_W'(DATA_W) - width_o;
   assign aligned_o = masked_o << shamt;
   assign zero_o    = (masked_o == '0);

endmodule

// File: rtl/ecnt_zero_scan.sv
module ecnt_zero_scan #(
   parameter int W        = 64,
   parameter bit FROM_TOP = 1'b0,
   parameter int CNT_W    = $clog2(W) + 1
) (
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             all_zero_o
);

   logic [W-1:0] scan_v;

   if (FROM_TOP) begin : g_rev
      for (genvar g = 0; g < W; g++) begin : g_bit
         assign scan_v[g] = vec_i[W-1-g];
      end
   end else begin : g_fwd
      assign scan_v = vec_i;
   end

   always_comb begin
      cnt_o = CNT_W'(W);
      for (int i = W - 1; i >= 0; i--) begin
         if (scan_v[i]) cnt_o = CNT_W'(i);
      end
   end

   assign all_zero_o = ~|scan_v;

endmodule

// File: rtl/ecnt_ones.sv
module ecnt_ones #(
   parameter int W     = 64,
   parameter int CNT_W = $clog2(W) + 1
) (
   input  logic [W-1:0]     vec_i,
   output logic [CNT_W-1:0] cnt_o
);

   localparam int GRP   = 8;
   localparam int NGRP  = W / GRP;
   localparam int GCW   = $clog2(GRP) + 1;

   logic [GCW-1:0] grp_cnt [NGRP];

   if (W % GRP != 0) begin : g_chk
      $error("ecnt_ones: width must be a multiple of 8");
   end

   for (genvar g = 0; g < NGRP; g++) begin : g_grp
      always_comb begin
         grp_cnt[g] = '0;
         for (int b = 0; b < GRP; b++) begin
            grp_cnt[g] = grp_cnt[g] + GCW'(vec_i[g*GRP + b]);
         end
      end
   end

   always_comb begin
      cnt_o = '0;
      for (int g = 0; g < NGRP; g++) begin
         cnt_o = cnt_o + CNT_W'(grp_cnt[g]);
      end
   end

endmodule

// File: rtl/ecnt_unit.sv
module ecnt_unit #(
   parameter int DATA_W = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              in_valid,
   input  logic [1:0]        in_op,
   input  logic [1:0]        in_ew,
   input  logic [DATA_W-1:0] in_operand,
   output logic              out_valid,
   output logic [DATA_W-1:0] out_result
);
   import ecnt_pkg::*;

   localparam int CNT_W = $clog2(DATA_W) + 1;
   localparam int SUM_W = CNT_W + 2;

   if (DATA_W < 64 || (DATA_W & (DATA_W - 1)) != 0) begin : g_chk
      $error("ecnt_unit: DATA_W must be a power of two of at least 64");
   end

   logic [DATA_W-1:0] masked, aligned;
   logic [CNT_W-1:0]  width;
   logic              elem_zero;
   logic [CNT_W-1:0]  lead_raw, trail_raw, ones_cnt;
   logic              lead_none, trail_none;
   logic [CNT_W-1:0]  lead_cnt, trail_cnt, sel_cnt;
   logic              valid_q;
   logic [CNT_W-1:0]  cnt_q;

   ecnt_lane_select #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_lane (
      .operand_i (in_operand),
      .ew_i      (in_ew),
      .masked_o  (masked),
      .aligned_o (aligned),
      .width_o   (width),
      .zero_o    (elem_zero)
   );

   ecnt_zero_scan #(.W(DATA_W), .FROM_TOP(1'b1), .CNT_W(CNT_W)) u_lead (
      .vec_i      (aligned),
      .cnt_o      (lead_raw),
      .all_zero_o (lead_none)
   );

   ecnt_zero_scan #(.W(DATA_W), .FROM_TOP(1'b0), .CNT_W(CNT_W)) u_trail (
      .vec_i      (masked),
      .cnt_o      (trail_raw),
      .all_zero_o (trail_none)
   );

   ecnt_ones #(.W(DATA_W), .CNT_W(CNT_W)) u_ones (
      .vec_i (masked),
      .cnt_o (ones_cnt)
   );

   // an empty element reports its own width, not the scanner's full span
   assign lead_cnt  = lead_none  ? width : lead_raw;
   assign trail_cnt = trail_none ? width : trail_raw;

   always_comb begin
      unique case (ecnt_op_e'(in_op))
         OP_LEAD:  sel_cnt = lead_cnt;
         OP_TRAIL: sel_cnt = trail_cnt;
         OP_ONES:  sel_cnt = ones_cnt;
         default:  sel_cnt = '0;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q <= 1'b0;
         cnt_q   <= '0;
      end else begin
         valid_q <= in_valid;
         if (in_valid) cnt_q <= sel_cnt;
      end
   end

   assign out_valid  = valid_q;
   assign out_result = {{(DATA_W-CNT_W){1'b0}}, cnt_q};

   AST_LAT_ONE: assert property (@(posedge clk) disable iff (!rst_n) in_valid |=> out_valid); // R8

   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> (!out_valid && $stable(out_result))); // R10

   AST_BLANK_IS_SEW: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && elem_zero && (in_op == 2'b00 || in_op == 2'b01))
      |=> (out_result == DATA_W'($past(width)))); // R4

   AST_SPAN_FITS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !elem_zero)
      |-> (({2'b00, lead_raw} + {2'b00, trail_raw}) < SUM_W'(width))); // R1

   AST_ONES_FIT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && !elem_zero)
      |-> (({2'b00, ones_cnt} + {2'b00, lead_raw} + {2'b00, trail_raw}) <= SUM_W'(width))); // R3

   AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> (out_result <= DATA_W'(DATA_W))); // R7

endmodule

// File: tb/ecnt_unit_tb.sv
module ecnt_unit_tb;

   localparam int CLK_PERIOD = 10;

   typedef struct {
      logic [63:0] res;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        in_valid = 1'b0;
   logic [1:0]  in_op = 2'b00;
   logic [1:0]  in_ew = 2'b00;
   logic [63:0] in_operand = '0;
   logic        out_valid;
   logic [63:0] out_result;

   int   checks = 0;
   int   errors = 0;
   bit   mon_on = 1'b0;
   bit   done   = 1'b0;
   exp_t exp_q[$];
   logic [63:0] last_exp = '0;
   logic [63:0] lfsr = 64'h9E37_79B9_7F4A_7C15;

   ecnt_unit u_dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_op      (in_op),
      .in_ew      (in_ew),
      .in_operand (in_operand),
      .out_valid  (out_valid),
      .out_result (out_result)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   task automatic check(input bit ok, input string tag, input logic [63:0] got, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   function automatic logic [63:0] model(input logic [1:0] op, input logic [1:0] ew, input logic [63:0] x);
      int  w;
      int  c;
      bit  found;
      w = 8 << ew;
      c = 0;
      found = 1'b0;
      case (op)
         2'b00: begin
            c = w;
            for (int i = 0; i < w; i++)
               if (!found && x[w-1-i]) begin c = i; found = 1'b1; end
         end
         2'b01: begin
            c = w;
            for (int i = 0; i < w; i++)
               if (!found && x[i]) begin c = i; found = 1'b1; end
         end
         2'b10: begin
            for (int i = 0; i < w; i++) c += int'(x[i]);
         end
         default: c = 0;
      endcase
      return 64'(c);
   endfunction

   function automatic logic [63:0] next_rand(input logic [63:0] s);
      logic [63:0] t;
      t = s ^ (s << 13);
      t = t ^ (t >> 7);
      t = t ^ (t << 17);
      return t;
   endfunction

   task automatic drive(input logic [1:0] op, input logic [1:0] ew, input logic [63:0] x, input string tag);
      exp_t e;
      @(negedge clk);
      in_valid   = 1'b1;
      in_op      = op;
      in_ew      = ew;
      in_operand = x;
      e.res = model(op, ew, x);
      e.tag = tag;
      exp_q.push_back(e);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid   = 1'b0;
         in_op      = 2'b11;
         in_operand = 64'hDEAD_BEEF_0BAD_F00D;
      end
   endtask

   // monitor: results are due one rising edge after capture
   initial begin
      forever begin
         @(posedge clk);
         #1;
         if (mon_on && !done) begin
            if (out_valid) begin
               if (exp_q.size() == 0) begin
                  check(1'b0, "R8 unexpected out_valid", 64'(out_valid), 64'd0);
               end else begin
                  exp_t e;
                  e = exp_q.pop_front();
                  check(out_result === e.res, e.tag, out_result, e.res);
                  last_exp = e.res;
               end
            end else begin
               if (exp_q.size() != 0) begin
                  check(1'b0, "R8 missing out_valid", 64'(out_valid), 64'd1);
                  void'(exp_q.pop_front());
               end
               check(out_result === last_exp, "R10 hold while idle", out_result, last_exp);
            end
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(out_valid === 1'b0, "R8 reset valid", 64'(out_valid), 64'd0);
      check(out_result === 64'd0, "R8 reset result", out_result, 64'd0);
      rst_n = 1'b1;
      mon_on = 1'b1;

      // leading, trailing, ones on simple values at each width
      for (int ew = 0; ew < 4; ew++) begin
         int w;
         w = 8 << ew;
         drive(2'b00, 2'(ew), 64'd1 << (w - 1), "R1 top bit set");
         drive(2'b00, 2'(ew), 64'd1, "R1 only bit 0");
         drive(2'b01, 2'(ew), 64'd1 << (w - 1), "R2 only top bit");
         drive(2'b01, 2'(ew), 64'd1, "R2 bit 0");
         drive(2'b10, 2'(ew), '1, "R5 all ones per width");
         drive(2'b00, 2'(ew), 64'd0, "R4 empty leading");
         drive(2'b01, 2'(ew), 64'd0, "R4 empty trailing");
         drive(2'b10, 2'(ew), 64'd0, "R3 empty ones");
         idle(1);
      end

      // bits above the element width must not matter
      for (int ew = 0; ew < 3; ew++) begin
         int w;
         w = 8 << ew;
         drive(2'b00, 2'(ew), ~((64'd1 << w) - 1), "R6 leading ignores upper");
         drive(2'b01, 2'(ew), ~((64'd1 << w) - 1), "R6 trailing ignores upper");
         drive(2'b10, 2'(ew), ~((64'd1 << w) - 1) | 64'd5, "R6 ones ignores upper");
         drive(2'b00, 2'(ew), ~((64'd1 << w) - 1) | 64'd1 << (w - 3), "R6 leading with upper junk");
      end

      // reserved opcode and full-width extension
      drive(2'b11, 2'b11, '1, "R9 reserved opcode");
      drive(2'b11, 2'b00, 64'h0F, "R9 reserved opcode narrow");
      drive(2'b00, 2'b11, 64'd0, "R7 full width zero-extended");
      idle(3);

      // back-to-back mixed requests
      for (int n = 0; n < 160; n++) begin
         logic [1:0] op;
         lfsr = next_rand(lfsr);
         op = 2'(lfsr[5:4] == 2'b11 ? 2'b10 : lfsr[5:4]);
         drive(op, lfsr[9:8],
               lfsr[62] ? (lfsr >> lfsr[17:12]) : lfsr,
               op == 2'b00 ? "R1 mixed" : (op == 2'b01 ? "R2 mixed" : "R3 mixed"));
         if (lfsr[33:31] == 3'b000) idle(2);
      end
      idle(4);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule